// File: doc/BRIEF.md
# Dual-Port Byte Transfer and Search Engine

This block is a byte-wide bus master that moves or inspects a run of bytes between two address ports, A and B. Each port owns a 16-bit address counter and a small flag byte. The flag byte chooses memory or I/O space and whether the address stays put, counts up or counts down. A direction bit in the base control byte decides which port is read and which is written. Each byte is read from the source and can be compared against a reference byte under a don't-care mask. It can then be written to the destination.

A byte counter is checked against a programmable block length. The run stops when that length is reached, when the counter wraps, or when a search hit occurs. On a stop, the block can raise an interrupt request. The request carries a vector whose bits 2:1 can be overwritten to show why the run stopped. Configuration arrives on parallel inputs and is captured when a start pulse is accepted. The bus side is a simple strobe and ready handshake with separate read and write strobes and a space select.

In continuous mode the bytes follow each other with no gap. In single-byte mode the engine waits for a service pulse before each byte.

Top module: `dxs_engine`

## Requirements
- R1: A start pulse is accepted only while idle and only if base control bit 0 (write enable) or bit 1 (search enable) is set; with both clear the engine stays idle (busy low) and drives no strobe.
- R2: Base control bit 2 set makes port A the source and port B the destination; bit 2 clear makes port B the source and port A the destination.
- R3: In a port flag byte, bit 3 set selects I/O space (bus_io high during that port's access). Bit 5 set keeps the address fixed. With bit 5 clear, bit 4 set counts up and bit 4 clear counts down, modulo 2^16.
- R4: The first byte after start uses the loaded start addresses unchanged, and both port addresses are stepped once before each later byte.
- R5: With search enabled, a byte hits when ((data XOR match_byte) AND NOT mask_byte) is zero (mask bit 1 = don't care); a hit sets match_flag and ends the run after that byte completes.
- R6: A byte counter starts at zero and counts completed bytes. The run ends with end_flag set when the counter wraps to zero, or when block_len is nonzero and the counter before the increment is at least block_len. A nonzero block_len N therefore moves N+1 bytes, and zero moves 65536.
- R7: A destination write phase (bus_wr) follows the read phase only when base control bit 0 is set, and the written data is the byte just read; read and write strobes are never high together.
- R8: With cont_mode high, bytes run back to back. With cont_mode low, exactly one byte is moved per svc_req pulse.
- R9: On a stop with int_en high, irq is raised if int_ctrl bit 0 is set and the run hit, or if int_ctrl bit 1 is set and the block ended. irq and irq_vec then hold until an int_ack pulse.
- R10: irq_vec is int_vec_base; when int_ctrl bit 5 is set, bits 2:1 are replaced with 01 for a hit cause (which takes priority) or 10 for an end-of-block cause.
- R11: A strobe with bus_ready low is held, with address and space unchanged, until bus_ready is high.
- R12: An accepted start clears match_flag, end_flag and the byte counter and reloads both address counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| cont_mode | input | 1 | 1 = continuous, 0 = one byte per svc_req |
| svc_req | input | 1 | Service pulse for single-byte mode |
| base_ctrl | input | 8 | Bit 0 write enable, bit 1 search enable, bit 2 direction |
| port_a_flags | input | 8 | Port A space and step flags |
| port_b_flags | input | 8 | Port B space and step flags |
| port_a_start | input | AW | Port A start address |
| port_b_start | input | AW | Port B start address |
| block_len | input | CW | Block length (0 = wrap only) |
| match_byte | input | DW | Search reference byte |
| mask_byte | input | DW | Search don't-care mask |
| int_en | input | 1 | Interrupt enable |
| int_ctrl | input | 8 | Bit 0 on hit, bit 1 on end, bit 5 vector patch |
| int_vec_base | input | 8 | Base interrupt vector |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | 1 = I/O space, 0 = memory |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Completes the current strobe |
| busy | output | 1 | Run in progress |
| match_flag | output | 1 | Search hit seen |
| end_flag | output | 1 | Block ended |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
A counting-up memory-to-memory copy and a B-to-A copy are run side by side. The second counts down on a memory source and writes to a fixed I/O address. Together they separate the direction bit, the two step directions, the fixed mode and the space select. Searches are tried twice: once with a mask under which only the masked nibble differs, so the first byte hits, and once unmasked, which must hit on the fourth byte. These tell the mask polarity apart from the plain compare. Copies are also run with a ready signal that stalls three cycles out of four, and in single-byte mode. Both must give the same bytes and addresses as the free-running copy. A run of 65536 reads that never hit shows the wrap ending.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dxs_state_t;

  // base control bit positions
  localparam int BC_WR   = 0;
  localparam int BC_SRCH = 1;
  localparam int BC_DIR  = 2;
  // port flag bit positions
  localparam int PF_IO   = 3;
  localparam int PF_INC  = 4;
  localparam int PF_FIX  = 5;
  // interrupt control bit positions
  localparam int IC_HIT  = 0;
  localparam int IC_END  = 1;
  localparam int IC_SUB  = 5;

endpackage

// File: rtl/dxs_port_addr.sv
module dxs_port_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_fix,
  input  logic          load_inc,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic fix_q, inc_q;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic fix, input logic inc);
    if (fix)      return a;
    else if (inc) return a + AW'(1);
    else          return a - AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      fix_q <= 1'b0;
      inc_q <= 1'b0;
    end else if (load) begin
      addr  <= load_addr;
      fix_q <= load_fix;
      inc_q <= load_inc;
    end else if (step) begin
      addr  <= next_addr(addr, fix_q, inc_q);
    end
  end

endmodule

// File: rtl/dxs_match.sv
module dxs_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] ref_byte,
  input  logic [DW-1:0] care_off,
  output logic          hit
);

  function automatic logic masked_equal(input logic [DW-1:0] d,
                                        input logic [DW-1:0] r,
                                        input logic [DW-1:0] m);
    return ((d ^ r) & ~m) == '0;
  endfunction

  assign hit = masked_equal(data, ref_byte, care_off);

endmodule

// File: rtl/dxs_block_cnt.sv
module dxs_block_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt;

  // true when the byte being completed closes the block
  function automatic logic closes_block(input logic [CW-1:0] c,
                                        input logic [CW-1:0] lim);
    logic [CW-1:0] nxt;
    nxt = c + CW'(1);
    return (nxt == '0) || ((lim != '0) && (c >= lim));
  endfunction

  assign last = closes_block(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/dxs_irq.sv
module dxs_irq
  import dxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       by_hit,
  input  logic       by_end,
  input  logic       int_en,
  input  logic [7:0] int_ctrl,
  input  logic [7:0] vec_base,
  input  logic       ack,
  output logic       irq,
  output logic [7:0] irq_vec
);

  logic want;

  function automatic logic [7:0] patch_vec(input logic [7:0] base,
                                           input logic [7:0] ctl,
                                           input logic hit_cause);
    logic [7:0] v;
    v = base;
    if (ctl[IC_SUB]) v[2:1] = hit_cause ? 2'b01 : 2'b10;
    return v;
  endfunction

  assign want = fire && int_en &&
                ((int_ctrl[IC_HIT] && by_hit) || (int_ctrl[IC_END] && by_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      irq_vec <= '0;
    end else if (!irq && want) begin
      irq     <= 1'b1;
      irq_vec <= patch_vec(vec_base, int_ctrl, int_ctrl[IC_HIT] && by_hit);
    end else if (ack) begin
      irq     <= 1'b0;
    end
  end

endmodule

// File: rtl/dxs_engine.sv
module dxs_engine
  import dxs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cont_mode,
  input  logic          svc_req,
  input  logic [7:0]    base_ctrl,
  input  logic [7:0]    port_a_flags,
  input  logic [7:0]    port_b_flags,
  input  logic [AW-1:0] port_a_start,
  input  logic [AW-1:0] port_b_start,
  input  logic [CW-1:0] block_len,
  input  logic [DW-1:0] match_byte,
  input  logic [DW-1:0] mask_byte,
  input  logic          int_en,
  input  logic [7:0]    int_ctrl,
  input  logic [7:0]    int_vec_base,
  input  logic          int_ack,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          match_flag,
  output logic          end_flag,
  output logic          irq,
  output logic [7:0]    irq_vec
);

  localparam int NPORT = 2;

  dxs_state_t st;

  logic          wr_en_q, srch_q, a_is_src_q, cont_q;
  logic          io_a_q, io_b_q;
  logic [DW-1:0] ref_q, care_off_q, data_q;
  logic [CW-1:0] len_q;
  logic          hit_q;

  // named internal events
  logic start_ok, rd_done, wr_done, byte_done;
  logic hit_now, hit_byte, stop_hit, stop_end, stop_now, step_now;
  logic blk_last;

  logic [AW-1:0] port_addr [NPORT];
  logic [AW-1:0] src_addr, dst_addr;
  logic          src_io, dst_io;

  logic unused_cfg;
  assign unused_cfg = ^{base_ctrl[7:3], port_a_flags[7:6], port_a_flags[2:0],
                        port_b_flags[7:6], port_b_flags[2:0],
                        int_ctrl[7:6], int_ctrl[4:2]};

  assign start_ok  = start && (st == ST_IDLE) && (base_ctrl[BC_WR] || base_ctrl[BC_SRCH]);
  assign rd_done   = (st == ST_READ)  && bus_ready;
  assign wr_done   = (st == ST_WRITE) && bus_ready;
  assign byte_done = (rd_done && !wr_en_q) || wr_done;

  dxs_match #(.DW(DW)) i_match (
    .data     (bus_rdata),
    .ref_byte (ref_q),
    .care_off (care_off_q),
    .hit      (hit_now)
  );

  assign hit_byte = wr_en_q ? hit_q : hit_now;
  assign stop_hit = byte_done && srch_q && hit_byte;
  assign stop_end = byte_done && blk_last;
  assign stop_now = stop_hit || stop_end;
  assign step_now = byte_done && !stop_now;

  // per-port address counters
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [AW-1:0] ld_addr;
      logic [7:0]    ld_flags;
      assign ld_addr  = (p == 0) ? port_a_start : port_b_start;
      assign ld_flags = (p == 0) ? port_a_flags : port_b_flags;
      dxs_port_addr #(.AW(AW)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .load_addr (ld_addr),
        .load_fix  (ld_flags[PF_FIX]),
        .load_inc  (ld_flags[PF_INC]),
        .step      (step_now),
        .addr      (port_addr[p])
      );
    end
  endgenerate

  assign src_addr = a_is_src_q ? port_addr[0] : port_addr[1];
  assign dst_addr = a_is_src_q ? port_addr[1] : port_addr[0];
  assign src_io   = a_is_src_q ? io_a_q : io_b_q;
  assign dst_io   = a_is_src_q ? io_b_q : io_a_q;

  dxs_block_cnt #(.CW(CW)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .inc   (byte_done),
    .limit (len_q),
    .last  (blk_last)
  );

  dxs_irq i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (stop_now),
    .by_hit   (stop_hit),
    .by_end   (stop_end),
    .int_en   (int_en),
    .int_ctrl (int_ctrl),
    .vec_base (int_vec_base),
    .ack      (int_ack),
    .irq      (irq),
    .irq_vec  (irq_vec)
  );

  // configuration capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q    <= 1'b0;
      srch_q     <= 1'b0;
      a_is_src_q <= 1'b0;
      cont_q     <= 1'b0;
      io_a_q     <= 1'b0;
      io_b_q     <= 1'b0;
      ref_q      <= '0;
      care_off_q <= '0;
      len_q      <= '0;
    end else if (start_ok) begin
      wr_en_q    <= base_ctrl[BC_WR];
      srch_q     <= base_ctrl[BC_SRCH];
      a_is_src_q <= base_ctrl[BC_DIR];
      cont_q     <= cont_mode;
      io_a_q     <= port_a_flags[PF_IO];
      io_b_q     <= port_b_flags[PF_IO];
      ref_q      <= match_byte;
      care_off_q <= mask_byte;
      len_q      <= block_len;
    end
  end

  // data path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hit_q  <= 1'b0;
    end else if (rd_done) begin
      data_q <= bus_rdata;
      hit_q  <= hit_now;
    end
  end

  // status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      end_flag   <= 1'b0;
    end else if (start_ok) begin
      match_flag <= 1'b0;
      end_flag   <= 1'b0;
    end else begin
      if (stop_hit) match_flag <= 1'b1;
      if (stop_end) end_flag   <= 1'b1;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  if (start_ok) st <= cont_mode ? ST_READ : ST_WAIT;
        ST_WAIT:  if (svc_req) st <= ST_READ;
        ST_READ: begin
          if (bus_ready) begin
            if (wr_en_q)       st <= ST_WRITE;
            else if (stop_now) st <= ST_IDLE;
            else               st <= cont_q ? ST_READ : ST_WAIT;
          end
        end
        ST_WRITE: begin
          if (bus_ready) begin
            if (stop_now) st <= ST_IDLE;
            else          st <= cont_q ? ST_READ : ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rd   = 1'b0;
    bus_wr   = 1'b0;
    bus_io   = 1'b0;
    bus_addr = '0;
    if (st == ST_READ) begin
      bus_rd   = 1'b1;
      bus_io   = src_io;
      bus_addr = src_addr;
    end else if (st == ST_WRITE) begin
      bus_wr   = 1'b1;
      bus_io   = dst_io;
      bus_addr = dst_addr;
    end
  end

  assign bus_wdata = data_q;
  assign busy      = (st != ST_IDLE);

endmodule

// File: rtl/dxs_chk.sv
module dxs_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    base_ctrl,
  input logic          busy,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_io,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          match_flag,
  input logic          irq,
  input logic [7:0]    irq_vec,
  input logic          int_ack,
  input logic          stop_now
);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_rd && !bus_wr)); // R1

  AST_NO_START_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (base_ctrl[1:0] == 2'b00)) |=> !busy); // R1

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr) && $stable(bus_io))); // R11

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_io))); // R11

  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> !busy); // R6

  AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> !busy); // R5

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !int_ack) |=> (irq && $stable(irq_vec))); // R9

endmodule

bind dxs_engine dxs_chk #(.AW(AW)) i_dxs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .base_ctrl  (base_ctrl),
  .busy       (busy),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_io     (bus_io),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .match_flag (match_flag),
  .irq        (irq),
  .irq_vec    (irq_vec),
  .int_ack    (int_ack),
  .stop_now   (stop_now)
);

// File: tb/test_dxs_engine.sv
`timescale 1ns/1ps
module test_dxs_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cont_mode = 1'b1, svc_req = 1'b0;
  logic [7:0]  base_ctrl = '0, fa = '0, fb = '0;
  logic [15:0] sa = '0, sb = '0, blen = '0;
  logic [7:0]  mbyte = '0, mmask = '0;
  logic        int_en = 1'b0, int_ack = 1'b0;
  logic [7:0]  int_ctrl = '0, vbase = '0;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, bus_io;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        busy, match_flag, end_flag, irq;
  logic [7:0]  irq_vec;

  always #2.5 clk = ~clk;

  // bus model
  logic [7:0]  mem [256];
  logic [7:0]  iom [256];
  logic [15:0] rd_log [64];
  logic [15:0] wr_log [64];
  logic        rd_io_log [64];
  logic        wr_io_log [64];
  int          rd_cnt, wr_cnt;
  logic        log_clr = 1'b0;
  logic        slow = 1'b0;
  logic [1:0]  phase;

  assign bus_ready = slow ? (phase == 2'b11) : 1'b1;
  assign bus_rdata = bus_io ? iom[bus_addr[7:0]] : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    phase <= phase + 2'd1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem[i] <= 8'(i) ^ 8'h5A;
        iom[i] <= 8'h11;
      end
      rd_cnt <= 0;
      wr_cnt <= 0;
      phase  <= 2'b00;
    end else if (log_clr) begin
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else begin
      if (bus_rd && bus_ready) begin
        if (rd_cnt < 64) begin
          rd_log[rd_cnt]    <= bus_addr;
          rd_io_log[rd_cnt] <= bus_io;
        end
        rd_cnt <= rd_cnt + 1;
      end
      if (bus_wr && bus_ready) begin
        if (wr_cnt < 64) begin
          wr_log[wr_cnt]    <= bus_addr;
          wr_io_log[wr_cnt] <= bus_io;
        end
        if (bus_io) iom[bus_addr[7:0]] <= bus_wdata;
        else        mem[bus_addr[7:0]] <= bus_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  dxs_engine i_dxs_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode), .svc_req(svc_req),
    .base_ctrl(base_ctrl), .port_a_flags(fa), .port_b_flags(fb),
    .port_a_start(sa), .port_b_start(sb), .block_len(blen),
    .match_byte(mbyte), .mask_byte(mmask), .int_en(int_en), .int_ctrl(int_ctrl),
    .int_vec_base(vbase), .int_ack(int_ack),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .match_flag(match_flag), .end_flag(end_flag),
    .irq(irq), .irq_vec(irq_vec)
  );

  int n_chk = 0, n_bad = 0;

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1; log_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; log_clr = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int n = 0;
    while (busy && n < limit) begin
      @(negedge clk);
      n++;
    end
    check("idle reached", {31'd0, busy}, 32'd0);
  endtask

  task automatic ack_irq();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic setup(input logic [7:0] bc, input logic [7:0] f_a, input logic [7:0] f_b,
                       input logic [15:0] s_a, input logic [15:0] s_b, input logic [15:0] len);
    base_ctrl = bc; fa = f_a; fb = f_b; sa = s_a; sb = s_b; blen = len;
  endtask

  task automatic t_reset();
    check("reset busy", {31'd0, busy}, 0);
    check("reset strobes", {30'd0, bus_rd, bus_wr}, 0);
    check("reset flags", {30'd0, match_flag, end_flag}, 0);
    check("reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_unconfigured();
    setup(8'h04, 8'h10, 8'h10, 16'h0010, 16'h0080, 16'd3);
    kick();
    cyc(6);
    check("R1 stays idle", {31'd0, busy}, 0);
    check("R1 no reads", rd_cnt, 0);
  endtask

  // copy A -> B, both memory, counting up, 4 bytes
  task automatic t_copy_up();
    setup(8'h05, 8'h10, 8'h10, 16'h0010, 16'h0080, 16'd3);
    kick();
    wait_idle(100);
    check("R6 four bytes read", rd_cnt, 4);
    check("R7 four bytes written", wr_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      check("R4 R2 read address", rd_log[i], 32'h10 + i);
      check("R3 write address up", wr_log[i], 32'h80 + i);
      check("R7 copied data", mem[8'h80 + i], pat(8'h10 + 8'(i)));
    end
    check("R6 end flag", {31'd0, end_flag}, 1);
    check("R5 no hit", {31'd0, match_flag}, 0);
  endtask

  // copy B -> A: B memory counting down, A I/O fixed
  task automatic t_copy_down_io();
    setup(8'h01, 8'h28, 8'h00, 16'h0007, 16'h0040, 16'd2);
    kick();
    wait_idle(100);
    check("R6 three bytes", rd_cnt, 3);
    for (int i = 0; i < 3; i++) begin
      check("R3 R2 down read address", rd_log[i], 32'h40 - i);
      check("R3 memory source space", {31'd0, rd_io_log[i]}, 0);
      check("R3 fixed write address", wr_log[i], 32'h07);
      check("R3 io write space", {31'd0, wr_io_log[i]}, 1);
    end
    check("R7 last io data", iom[8'h07], pat(8'h3E));
  endtask

  // masked search: only the don't-care nibble differs on the first byte
  task automatic t_search_masked();
    setup(8'h06, 8'h10, 8'h10, 16'h0020, 16'h0000, 16'd0);
    mbyte = pat(8'h20) ^ 8'h0F; mmask = 8'h0F;
    int_en = 1'b1; int_ctrl = 8'h21; vbase = 8'h80;
    kick();
    wait_idle(100);
    check("R5 masked hit after one byte", rd_cnt, 1);
    check("R7 search only no write", wr_cnt, 0);
    check("R5 match flag", {31'd0, match_flag}, 1);
    cyc(1);
    check("R9 irq on hit", {31'd0, irq}, 1);
    check("R10 hit vector", irq_vec, 8'h82);
    cyc(4);
    check("R9 irq held", {31'd0, irq}, 1);
    ack_irq();
    check("R9 irq cleared by ack", {31'd0, irq}, 0);
  endtask

  // restart after a hit: flags clear, new addresses
  task automatic t_restart();
    setup(8'h05, 8'h10, 8'h10, 16'h0050, 16'h0090, 16'd1);
    int_en = 1'b1; int_ctrl = 8'h22; vbase = 8'hF0;
    kick();
    check("R12 match flag cleared", {31'd0, match_flag}, 0);
    check("R12 first read reloaded", bus_addr, 16'h0050);
    wait_idle(100);
    check("R12 reloaded dest", wr_log[0], 32'h90);
    check("R6 two bytes for len 1", rd_cnt, 2);
    cyc(1);
    check("R9 irq on end", {31'd0, irq}, 1);
    check("R10 end vector", irq_vec, 8'hF4);
    ack_irq();
    setup(8'h05, 8'h10, 8'h10, 16'h0054, 16'h0094, 16'd0);
    blen = 16'd1; int_ctrl = 8'h02; vbase = 8'hF6;
    kick();
    wait_idle(100);
    cyc(1);
    check("R10 vector unpatched", irq_vec, 8'hF6);
    ack_irq();
  endtask

  // exact search: fourth byte hits; only end interrupts enabled
  task automatic t_search_exact();
    setup(8'h06, 8'h10, 8'h10, 16'h0020, 16'h0000, 16'd0);
    mbyte = pat(8'h23); mmask = 8'h00;
    int_en = 1'b1; int_ctrl = 8'h02; vbase = 8'h40;
    kick();
    wait_idle(100);
    check("R5 exact hit on fourth byte", rd_cnt, 4);
    check("R5 last read address", rd_log[3], 32'h23);
    check("R5 match flag", {31'd0, match_flag}, 1);
    cyc(2);
    check("R9 no irq when hit not enabled", {31'd0, irq}, 0);
    int_en = 1'b0;
  endtask

  task automatic t_byte_mode();
    cont_mode = 1'b0;
    setup(8'h05, 8'h10, 8'h10, 16'h0030, 16'h00B0, 16'd2);
    kick();
    cyc(5);
    check("R8 waits for service", rd_cnt, 0);
    check("R8 busy while waiting", {31'd0, busy}, 1);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); svc_req = 1'b1;
      @(negedge clk); svc_req = 1'b0;
      cyc(5);
      check("R8 one byte per request", rd_cnt, k);
      check("R8 one write per request", wr_cnt, k);
    end
    check("R8 done after three", {31'd0, busy}, 0);
    check("R4 stepped in byte mode", rd_log[2], 32'h32);
    cont_mode = 1'b1;
  endtask

  task automatic t_wait_states();
    slow = 1'b1;
    setup(8'h05, 8'h10, 8'h10, 16'h0060, 16'h00A0, 16'd3);
    kick();
    wait_idle(200);
    check("R11 reads with stalls", rd_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      check("R11 addresses under stall", rd_log[i], 32'h60 + i);
      check("R11 data under stall", mem[8'hA0 + i], pat(8'h60 + 8'(i)));
    end
    slow = 1'b0;
  endtask

  // no hit, no limit: ends on counter wrap after 65536 bytes
  task automatic t_wrap();
    setup(8'h06, 8'h28, 8'h00, 16'h0033, 16'h0000, 16'd0);
    mbyte = 8'h22; mmask = 8'h00;
    kick();
    wait_idle(70000);
    check("R6 wrap length", rd_cnt, 65536);
    check("R6 wrap end flag", {31'd0, end_flag}, 1);
    check("R3 fixed io source", rd_log[63], 32'h33);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_unconfigured();
    t_copy_up();
    t_copy_down_io();
    t_search_masked();
    t_restart();
    t_search_exact();
    t_byte_mode();
    t_wait_states();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule